// File: doc/BRIEF.md
# Write-Completion Polling Read Path

This block is the read side of a byte-wide nonvolatile page memory. A host read is qualified when chip-enable and output-enable are both low while write-enable is high. When no internal program or erase cycle is in progress, the block returns the byte that the array presents. While such a cycle is running, the array cannot be read, so the block returns a status byte instead. The host polls that byte to learn when the cycle has finished.

The status byte has three parts. The top bit is the complement of the top bit of the most recently loaded byte. The next bit flips between successive read accesses. The remaining low bits repeat the loaded byte. When the cycle ends, the array data comes back, so the top bit matches the true data again and the flipping bit stops changing. A host can detect completion either way: two reads in a row that give the same flipping bit, or a top bit that equals the value written.

Everything runs on one clock with a synchronous active-high reset, and the bus pins arrive already synchronous to that clock. The data byte and the tri-state enable leave through registers, one clock after the inputs are sampled. The storage array and the write timers are outside this block. The busy flag, the last loaded byte and the array byte arrive as inputs.

Top module: `poll_read_path`

## Requirements
- R1: `dq_oe` is 1 in the cycle after `ce_n`=0, `oe_n`=0 and `we_n`=1 are sampled together, and 0 otherwise. Whenever `dq_oe` is 0, `dq_out` is 8'h00.
- R2: During a read with `busy`=0, `dq_out` equals the `array_data` sampled in the previous cycle, including bits 7 and 6.
- R3: During a read with `busy`=1, `dq_out` bit 7 is the complement of `last_data` bit 7.
- R4: During a read with `busy`=1, `dq_out` bits 5..0 equal `last_data` bits 5..0.
- R5: During a read with `busy`=1, `dq_out` bit 6 is the toggle state. The toggle state inverts once at the end of each read access, that is, on the first cycle where the read qualification drops after being true. It holds steady for the whole length of one access.
- R6: When `busy` rises, the toggle state is cleared. The first status read after that rise, including a read already in progress at the rise, shows 0 on bit 6.
- R7: A cycle with `we_n`=0 is not a read, even if `ce_n` and `oe_n` are low. `dq_oe` stays 0, and the cycle neither starts nor ends an access, so the toggle state does not advance.
- R8: Reset (`rst`=1) forces `dq_oe` to 0, `dq_out` to 0 and the toggle state to 0.
- R9: After `busy` falls, reads return `array_data` at once on every bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; low blocks a read |
| busy | input | 1 | Internal program or erase cycle in progress |
| last_data | input | DATA_W (8) | Most recently loaded byte |
| array_data | input | DATA_W (8) | Byte read from the storage array |
| dq_out | output | DATA_W (8) | Registered read data, 0 when not driving |
| dq_oe | output | 1 | Registered tri-state enable for the data bus |

## Verification
A sequence of vectors reads the block in several ways:
- Idle reads with changing array bytes show that the array path is transparent and that its data is not mixed with the last loaded byte.
- Busy reads with loaded bytes whose top bits differ tell the inverted polling bit apart from the pass-through low bits.
- Long reads, short reads and deselect gaps tell a per-access toggle apart from a per-clock toggle.
- Reads blocked by a write strobe show that a write does not count as an access.
- A busy rise during an open read and a reset in the middle of a read pin down when the toggle is cleared.
- A run of alternating accesses checks that bit 6 keeps flipping over many reads.

// File: rtl/poll_read_pkg.sv
package poll_read_pkg;

  // A bus access counts as a read only with both selects low and no write strobe.
  function automatic logic read_qualified(input logic ce_n, input logic oe_n,
                                          input logic we_n);
    return (!ce_n) && (!oe_n) && we_n;
  endfunction

endpackage

// File: rtl/poll_read_qual.sv
module poll_read_qual
  import poll_read_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic rd_en,
  output logic rd_done
);

  logic rd_en_q;

  assign rd_en = read_qualified(ce_n, oe_n, we_n);

  always_ff @(posedge clk) begin
    if (rst) rd_en_q <= 1'b0;
    else     rd_en_q <= rd_en;
  end

  // End of access: qualification was true last cycle and has dropped now.
  assign rd_done = rd_en_q && !rd_en;

  AST_DONE_NEEDS_PRIOR_READ: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> $past(rd_en)) else $error("read end without a read"); // R5

  AST_WRITE_NOT_READ: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> !rd_en) else $error("write strobe qualified as read"); // R7

endmodule

// File: rtl/poll_read_toggle.sv
module poll_read_toggle (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic rd_done,
  output logic tgl_bit,
  output logic busy_rise
);

  logic busy_q;
  logic tgl_q;

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= busy;
  end

  assign busy_rise = busy && !busy_q;

  // Clearing on a new busy period wins over advancing on a read end.
  always_ff @(posedge clk) begin
    if (rst)            tgl_q <= 1'b0;
    else if (busy_rise) tgl_q <= 1'b0;
    else if (rd_done)   tgl_q <= ~tgl_q;
  end

  // In the edge where busy rises the register still holds the old value.
  assign tgl_bit = busy_rise ? 1'b0 : tgl_q;

  AST_TOGGLE_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    (rd_done && !busy_rise) |=> (tgl_q != $past(tgl_q)))
    else $error("toggle did not advance"); // R5

  AST_TOGGLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!rd_done && !busy_rise) |=> $stable(tgl_q))
    else $error("toggle moved without an access end"); // R5

  AST_TOGGLE_CLEARED: assert property (@(posedge clk) disable iff (rst)
    busy_rise |=> !tgl_q) else $error("toggle not cleared on busy rise"); // R6

endmodule

// File: rtl/poll_read_mux.sv
module poll_read_mux #(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = DATA_W - 1,
  parameter int TOGGLE_BIT = DATA_W - 2
) (
  input  logic              busy,
  input  logic              tgl_bit,
  input  logic [DATA_W-1:0] last_data,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_word
);

  logic [DATA_W-1:0] status;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b == POLL_BIT) begin : g_poll
      assign status[b] = ~last_data[b];
    end else if (b == TOGGLE_BIT) begin : g_tgl
      assign status[b] = tgl_bit;
    end else begin : g_pass
      assign status[b] = last_data[b];
    end
  end

  assign rd_word = busy ? status : array_data;

endmodule

// File: rtl/poll_read_path.sv
module poll_read_path #(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = DATA_W - 1,
  parameter int TOGGLE_BIT = DATA_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              busy,
  input  logic [DATA_W-1:0] last_data,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  localparam logic [DATA_W-1:0] IDLE_WORD = '0;

  logic              rd_en;
  logic              rd_done;
  logic              tgl_bit;
  logic              busy_rise;
  logic [DATA_W-1:0] rd_word;

  poll_read_qual i_qual (
    .clk     (clk),
    .rst     (rst),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .we_n    (we_n),
    .rd_en   (rd_en),
    .rd_done (rd_done)
  );

  poll_read_toggle i_toggle (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .rd_done   (rd_done),
    .tgl_bit   (tgl_bit),
    .busy_rise (busy_rise)
  );

  poll_read_mux #(
    .DATA_W     (DATA_W),
    .POLL_BIT   (POLL_BIT),
    .TOGGLE_BIT (TOGGLE_BIT)
  ) i_mux (
    .busy       (busy),
    .tgl_bit    (tgl_bit),
    .last_data  (last_data),
    .array_data (array_data),
    .rd_word    (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_oe  <= 1'b0;
      dq_out <= IDLE_WORD;
    end else begin
      dq_oe  <= rd_en;
      dq_out <= rd_en ? rd_word : IDLE_WORD;
    end
  end

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !oe_n && we_n) |=> dq_oe) else $error("read not driven"); // R1

  AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (rst)
    (ce_n || oe_n || !we_n) |=> !dq_oe) else $error("bus driven without read"); // R1

  AST_HIZ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !dq_oe |-> (dq_out == IDLE_WORD)) else $error("data not zero when idle"); // R1

  AST_IDLE_ARRAY: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !busy) |=> (dq_out == $past(array_data)))
    else $error("idle read not array data"); // R2

  AST_POLL_INVERT: assert property (@(posedge clk) disable iff (rst)
    (rd_en && busy) |=> (dq_out[POLL_BIT] != $past(last_data[POLL_BIT])))
    else $error("poll bit not inverted"); // R3

endmodule

// File: tb/test_poll_read_path.sv
module test_poll_read_path;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, busy = 1'b0;
  logic [7:0] last_data = 8'h00, array_data = 8'h00;
  logic [7:0] dq_out;
  logic       dq_oe;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #10 clk = ~clk;

  poll_read_path i_poll_read_path (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .busy(busy),
    .last_data(last_data), .array_data(array_data), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // vector: ce,oe,we,busy,last[8],arr[8],exp_oe,exp_data[8],req[4]
  function automatic logic [32:0] mk(input logic ce, input logic oe, input logic we,
      input logic bz, input logic [7:0] ld, input logic [7:0] ad,
      input logic eo, input logic [7:0] ed, input logic [3:0] rq);
    return {ce, oe, we, bz, ld, ad, eo, ed, rq};
  endfunction

  localparam int NV = 23;
  localparam logic [32:0] VEC [NV] = '{
    mk(0,0,1,0,8'h5A,8'h3C,1,8'h3C,2),  // R2 idle read
    mk(1,0,1,0,8'h5A,8'hC3,0,8'h00,1),  // R1 deselected
    mk(0,1,1,0,8'h5A,8'hC3,0,8'h00,1),  // R1 output disabled
    mk(1,1,1,1,8'hA5,8'hFF,0,8'h00,1),  // busy rises, no read
    mk(0,0,1,1,8'hA5,8'hFF,1,8'h25,6),  // R6 first status read bit6=0, R3 R4
    mk(0,0,1,1,8'hA5,8'h00,1,8'h25,5),  // R5 same access holds
    mk(0,1,1,1,8'hA5,8'h00,0,8'h00,1),  // access ends
    mk(0,0,1,1,8'hA5,8'h00,1,8'h65,5),  // R5 flipped
    mk(1,1,1,1,8'hA5,8'h00,0,8'h00,1),
    mk(0,0,1,1,8'h3C,8'h00,1,8'hBC,3),  // R3 inverted top bit, R4 low bits
    mk(0,0,0,1,8'h3C,8'h00,0,8'h00,7),  // R7 write blocks read (ends access)
    mk(1,1,1,1,8'h3C,8'h00,0,8'h00,1),
    mk(0,0,0,1,8'h3C,8'h00,0,8'h00,7),  // R7 write, no access
    mk(1,1,1,1,8'h3C,8'h00,0,8'h00,1),
    mk(0,0,1,1,8'h3C,8'h00,1,8'hFC,7),  // R7 toggle advanced once only
    mk(1,1,1,1,8'h3C,8'h00,0,8'h00,1),
    mk(0,0,1,0,8'h3C,8'h3C,1,8'h3C,9),  // R9 true data after busy falls
    mk(0,0,1,0,8'h3C,8'h81,1,8'h81,2),  // R2 array follows
    mk(1,1,1,0,8'h3C,8'h81,0,8'h00,1),
    mk(0,0,1,1,8'hFF,8'hAA,1,8'h3F,6),  // R6 busy rises during read
    mk(0,0,1,1,8'hFF,8'hAA,1,8'h3F,6),  // R6 cleared state kept
    mk(1,1,1,1,8'hFF,8'hAA,0,8'h00,1),
    mk(0,0,1,1,8'hFF,8'hAA,1,8'h7F,5)   // R5 flipped after clear
  };

  task automatic chk(input int rq, input logic eo, input logic [7:0] ed);
    n_chk++;
    if (dq_oe !== eo || dq_out !== ed) begin
      n_bad++;
      $display("FAIL R%0d: actual oe=%b data=%h expected oe=%b data=%h",
               rq, dq_oe, dq_out, eo, ed);
    end
  endtask

  task automatic step(input logic ce, input logic oe, input logic we, input logic bz,
                      input logic [7:0] ld, input logic [7:0] ad);
    ce_n = ce; oe_n = oe; we_n = we; busy = bz; last_data = ld; array_data = ad;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_bad++;
      $display("FAIL watchdog: actual cycles %0d expected below 5000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(8, 1'b0, 8'h00);                       // R8 reset state
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      v = VEC[i];
      step(v[32], v[31], v[30], v[29], v[28:21], v[20:13]);
      chk(int'(v[3:0]), v[12], v[11:4]);
    end

    // R8: reset in the middle of a busy read clears outputs and toggle
    rst = 1'b1;
    step(0, 0, 1, 1, 8'hFF, 8'hAA);
    chk(8, 1'b0, 8'h00);
    step(0, 0, 1, 1, 8'hFF, 8'hAA);
    chk(8, 1'b0, 8'h00);
    rst = 1'b0;
    step(0, 0, 1, 1, 8'hFF, 8'hAA);
    chk(8, 1'b1, 8'h3F);                       // R8 toggle back at 0

    // R5: run of short accesses alternates bit 6
    for (int i = 0; i < 8; i++) begin
      step(1, 1, 1, 1, 8'hFF, 8'hAA);
      chk(1, 1'b0, 8'h00);
      step(0, 0, 1, 1, 8'hFF, 8'hAA);
      chk(5, 1'b1, (i % 2 == 0) ? 8'h7F : 8'h3F);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule